// File: doc/BRIEF.md
# Programming Supply Write Sequencer

This block times the high-voltage programming supply around a single row write of a resistive memory array. When a write is requested it switches the supply on and lets it settle for a set lead time. It then drives the row write pulse for a fixed duration. After the pulse it keeps the supply on for a discharge interval, switches the supply off, and reports completion with a one-cycle done pulse. The supply stays off while the sequencer is idle and while a read is being served.

The block also drives a two-bit bias mode code to the cell bias drivers. The code selects idle, read, set (move the cell to low resistance) or reset (move the cell to high resistance). All three intervals are given in microseconds and turned into cycle counts from the clock frequency in kHz. With the default settings the lead is 20 µs, the pulse 1 ms and the discharge 10 µs. One down-counter times every interval.

Top module: `vpp_write_seq`

## Requirements
- R1: While `rst_n` is low, `vpp_en_o`, `wr_pulse_o` and `done_o` are 0 and `mode_o` is 2'b00. Asserting `rst_n` in the middle of a sequence clears `vpp_en_o` and `wr_pulse_o` at once, without waiting for a clock edge, and the sequencer restarts in idle.
- R2: After a write request is taken, `vpp_en_o` rises on the next clock edge. It stays high for exactly RAMP_CYC = CLK_KHZ*RAMP_US/1000 cycles (at least 1) before `wr_pulse_o` rises.
- R3: `wr_pulse_o` stays high for exactly PULSE_CYC = CLK_KHZ*PULSE_US/1000 cycles, and `vpp_en_o` is high in every one of those cycles.
- R4: When `wr_pulse_o` falls, `vpp_en_o` stays high for exactly HOLD_CYC = CLK_KHZ*HOLD_US/1000 more cycles and then falls.
- R5: `done_o` is high for exactly one cycle: the first cycle in which `vpp_en_o` is low again after the discharge interval.
- R6: `vpp_en_o` is low in idle and while a read is served, and `wr_pulse_o` is never high unless `vpp_en_o` is high.
- R7: Mode encoding: 2'b00 idle, 2'b01 read, 2'b10 set (write with `wr_sel_reset`=0), 2'b11 reset (write with `wr_sel_reset`=1). The write code appears in the same cycle as `vpp_en_o`. It stays constant for as long as `vpp_en_o` is high, and it is 2'b00 in the done cycle.
- R8: If `wr_req` and `rd_req` are both high in idle, the write wins. The sequence runs and the mode is the write code.
- R9: `wr_req`, `rd_req` and `wr_sel_reset` have no effect while a sequence is in progress. The interval lengths and the mode stay unchanged, and no second sequence follows unless a new request is made in idle.
- R10: A read request is taken only in idle. `mode_o` becomes 2'b01 one cycle after `rd_req` is sampled high and returns to 2'b00 one cycle after `rd_req` is sampled low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_req | input | 1 | Request a row write sequence |
| wr_sel_reset | input | 1 | Write polarity: 0 set, 1 reset |
| rd_req | input | 1 | Request read bias |
| vpp_en_o | output | 1 | Programming supply enable |
| wr_pulse_o | output | 1 | Row write pulse |
| done_o | output | 1 | One-cycle completion pulse |
| mode_o | output | 2 | Bias mode code for the cell drivers |

## Verification
The assertions assume that `rst_n` is the only asynchronous input and that the request inputs change only away from the rising edge. They also assume that the interval parameters give counts of at least one cycle, so every timed state lasts at least one cycle. The bench drives every input on the falling edge and chooses lead, pulse and discharge lengths that differ from one another, so a swapped or mis-counted interval shows up in the measured lengths. Requests made during a sequence are raised and then dropped again while the pulse is still high, so they end before the sequence returns to idle.

// File: rtl/vpp_seq_pkg.sv
package vpp_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_RAMP  = 3'd1,
    ST_PULSE = 3'd2,
    ST_HOLD  = 3'd3,
    ST_DONE  = 3'd4
  } seq_state_t;

  typedef enum logic [1:0] {
    MODE_IDLE  = 2'b00,
    MODE_READ  = 2'b01,
    MODE_SET   = 2'b10,
    MODE_RESET = 2'b11
  } bias_mode_t;

  function automatic int unsigned us_to_cycles(input int unsigned khz,
                                               input int unsigned us);
    int unsigned raw;
    raw = (khz * us) / 1000;
    return (raw < 1) ? 1 : raw;
  endfunction

endpackage

// File: rtl/vpp_seq_rstsync.sv
module vpp_seq_rstsync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/vpp_seq_timer.sv
module vpp_seq_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             zero_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nxt;
  logic             cnt_en;

  assign zero_o = (cnt_q == '0);
  assign cnt_en = load_i | ~zero_o;

  always_comb begin
    cnt_nxt = cnt_q;
    if (load_i) begin
      cnt_nxt = load_val_i;
    end else if (!zero_o) begin
      cnt_nxt = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_nxt;
    end
  end

  // R2
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && zero_o) |=> zero_o);

endmodule

// File: rtl/vpp_seq_fsm.sv
module vpp_seq_fsm
  import vpp_seq_pkg::*;
#(
  parameter int unsigned CNT_W    = 8,
  parameter int unsigned RAMP_LD  = 1,
  parameter int unsigned PULSE_LD = 1,
  parameter int unsigned HOLD_LD  = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_req_i,
  input  logic             sel_reset_i,
  input  logic             rd_req_i,
  input  logic             tmr_zero_i,
  output logic             tmr_load_o,
  output logic [CNT_W-1:0] tmr_val_o,
  output logic             vpp_en_o,
  output logic             wr_pulse_o,
  output logic             done_o,
  output logic [1:0]       mode_o
);

  seq_state_t st_q, st_nxt;
  bias_mode_t mode_q, mode_nxt;
  logic       mode_en;

  always_comb begin
    st_nxt     = st_q;
    mode_nxt   = mode_q;
    mode_en    = 1'b0;
    tmr_load_o = 1'b0;
    tmr_val_o  = '0;
    unique case (st_q)
      ST_IDLE: begin
        mode_en = 1'b1;
        if (wr_req_i) begin
          st_nxt     = ST_RAMP;
          tmr_load_o = 1'b1;
          tmr_val_o  = CNT_W'(RAMP_LD);
          mode_nxt   = sel_reset_i ? MODE_RESET : MODE_SET;
        end else if (rd_req_i) begin
          mode_nxt = MODE_READ;
        end else begin
          mode_nxt = MODE_IDLE;
        end
      end
      ST_RAMP: begin
        if (tmr_zero_i) begin
          st_nxt     = ST_PULSE;
          tmr_load_o = 1'b1;
          tmr_val_o  = CNT_W'(PULSE_LD);
        end
      end
      ST_PULSE: begin
        if (tmr_zero_i) begin
          st_nxt     = ST_HOLD;
          tmr_load_o = 1'b1;
          tmr_val_o  = CNT_W'(HOLD_LD);
        end
      end
      ST_HOLD: begin
        if (tmr_zero_i) begin
          st_nxt   = ST_DONE;
          mode_en  = 1'b1;
          mode_nxt = MODE_IDLE;
        end
      end
      ST_DONE: begin
        st_nxt = ST_IDLE;
      end
      default: begin
        st_nxt   = ST_IDLE;
        mode_en  = 1'b1;
        mode_nxt = MODE_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
    end else begin
      st_q <= st_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_IDLE;
    end else if (mode_en) begin
      mode_q <= mode_nxt;
    end
  end

  assign vpp_en_o   = (st_q == ST_RAMP) || (st_q == ST_PULSE) || (st_q == ST_HOLD);
  assign wr_pulse_o = (st_q == ST_PULSE);
  assign done_o     = (st_q == ST_DONE);
  assign mode_o     = mode_q;

  // R6
  pulse_needs_supply_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pulse_o |-> vpp_en_o);

  // R3
  pulse_after_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_pulse_o) |-> $past(vpp_en_o));

  // R5
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R4
  supply_off_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(vpp_en_o) |-> (done_o && !wr_pulse_o));

  // R7
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vpp_en_o && $past(vpp_en_o)) |-> $stable(mode_o));

  // R7
  mode_write_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vpp_en_o |-> mode_o[1]);

endmodule

// File: rtl/vpp_write_seq.sv
module vpp_write_seq
  import vpp_seq_pkg::*;
#(
  parameter int unsigned CLK_KHZ  = 50000,
  parameter int unsigned RAMP_US  = 20,
  parameter int unsigned PULSE_US = 1000,
  parameter int unsigned HOLD_US  = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_req,
  input  logic       wr_sel_reset,
  input  logic       rd_req,
  output logic       vpp_en_o,
  output logic       wr_pulse_o,
  output logic       done_o,
  output logic [1:0] mode_o
);

  localparam int unsigned RAMP_CYC  = us_to_cycles(CLK_KHZ, RAMP_US);
  localparam int unsigned PULSE_CYC = us_to_cycles(CLK_KHZ, PULSE_US);
  localparam int unsigned HOLD_CYC  = us_to_cycles(CLK_KHZ, HOLD_US);
  localparam int unsigned MAX_A     = (RAMP_CYC > PULSE_CYC) ? RAMP_CYC : PULSE_CYC;
  localparam int unsigned MAX_CYC   = (MAX_A > HOLD_CYC) ? MAX_A : HOLD_CYC;
  localparam int unsigned CNT_W     = ($clog2(MAX_CYC) < 1) ? 1 : $clog2(MAX_CYC);

  logic             rst_n_sync;
  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             tmr_zero;

  vpp_seq_rstsync #(
    .STAGES(2)
  ) u_rstsync (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_n_sync(rst_n_sync)
  );

  vpp_seq_timer #(
    .CNT_W(CNT_W)
  ) u_timer (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .load_i    (tmr_load),
    .load_val_i(tmr_val),
    .zero_o    (tmr_zero)
  );

  vpp_seq_fsm #(
    .CNT_W   (CNT_W),
    .RAMP_LD (RAMP_CYC - 1),
    .PULSE_LD(PULSE_CYC - 1),
    .HOLD_LD (HOLD_CYC - 1)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n_sync),
    .wr_req_i   (wr_req),
    .sel_reset_i(wr_sel_reset),
    .rd_req_i   (rd_req),
    .tmr_zero_i (tmr_zero),
    .tmr_load_o (tmr_load),
    .tmr_val_o  (tmr_val),
    .vpp_en_o   (vpp_en_o),
    .wr_pulse_o (wr_pulse_o),
    .done_o     (done_o),
    .mode_o     (mode_o)
  );

endmodule

// File: tb/vpp_write_seq_tb.sv
module vpp_write_seq_tb;

  localparam int unsigned CLK_KHZ  = 250000;
  localparam int unsigned RAMP_US  = 2;
  localparam int unsigned PULSE_US = 4;
  localparam int unsigned HOLD_US  = 1;
  localparam int EXP_RAMP  = 500;
  localparam int EXP_PULSE = 1000;
  localparam int EXP_HOLD  = 250;
  localparam int GUARD     = 5000;

  logic       clk;
  logic       rst_n;
  logic       wr_req;
  logic       wr_sel_reset;
  logic       rd_req;
  logic       vpp_en_o;
  logic       wr_pulse_o;
  logic       done_o;
  logic [1:0] mode_o;

  int checks;
  int errors;
  int cyc;

  vpp_write_seq #(
    .CLK_KHZ (CLK_KHZ),
    .RAMP_US (RAMP_US),
    .PULSE_US(PULSE_US),
    .HOLD_US (HOLD_US)
  ) u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_req      (wr_req),
    .wr_sel_reset(wr_sel_reset),
    .rd_req      (rd_req),
    .vpp_en_o    (vpp_en_o),
    .wr_pulse_o  (wr_pulse_o),
    .done_o      (done_o),
    .mode_o      (mode_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual=%0d cycles expected<=150000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  // Runs one write sequence from idle and measures every interval.
  task automatic run_write(input bit sel_rst, input bit with_rd, input bit poke,
                           input string tag);
    int ramp_n, pulse_n, hold_n, g, mode_bad, extra_vpp;
    logic [1:0] exp_mode;
    exp_mode = sel_rst ? 2'b11 : 2'b10;
    @(negedge clk);
    wr_req = 1'b1; wr_sel_reset = sel_rst; rd_req = with_rd;
    @(negedge clk);
    wr_req = 1'b0; rd_req = 1'b0;
    chk(vpp_en_o === 1'b1, {"R2 supply on after request ", tag}, int'(vpp_en_o), 1);
    ramp_n = 0; pulse_n = 0; hold_n = 0; g = 0; mode_bad = 0;
    while (vpp_en_o && !wr_pulse_o && g < GUARD) begin
      if (mode_o !== exp_mode) mode_bad++;
      ramp_n++; g++; @(negedge clk);
    end
    while (wr_pulse_o && g < GUARD) begin
      if (mode_o !== exp_mode || !vpp_en_o) mode_bad++;
      pulse_n++; g++;
      if (poke && pulse_n == 10) begin
        wr_req = 1'b1; rd_req = 1'b1; wr_sel_reset = ~sel_rst;
      end
      if (poke && pulse_n == 30) begin
        wr_req = 1'b0; rd_req = 1'b0; wr_sel_reset = sel_rst;
      end
      @(negedge clk);
    end
    while (vpp_en_o && !wr_pulse_o && g < GUARD) begin
      if (mode_o !== exp_mode) mode_bad++;
      hold_n++; g++; @(negedge clk);
    end
    chk(ramp_n == EXP_RAMP, {"R2 lead length ", tag}, ramp_n, EXP_RAMP);
    chk(pulse_n == EXP_PULSE, {"R3 pulse length ", tag}, pulse_n, EXP_PULSE);
    chk(hold_n == EXP_HOLD, {"R4 discharge length ", tag}, hold_n, EXP_HOLD);
    chk(mode_bad == 0, {"R7 mode held during sequence ", tag}, mode_bad, 0);
    chk(done_o === 1'b1 && mode_o === 2'b00, {"R5 done after supply off ", tag},
        int'(done_o), 1);
    @(negedge clk);
    chk(done_o === 1'b0, {"R5 done lasts one cycle ", tag}, int'(done_o), 0);
    extra_vpp = 0;
    repeat (20) begin
      if (vpp_en_o || wr_pulse_o) extra_vpp++;
      @(negedge clk);
    end
    chk(extra_vpp == 0, {"R9 R6 no further sequence ", tag}, extra_vpp, 0);
  endtask

  task automatic test_reset_state();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk(vpp_en_o === 1'b0 && wr_pulse_o === 1'b0 && done_o === 1'b0,
        "R1 outputs low in reset", int'(vpp_en_o), 0);
    chk(mode_o === 2'b00, "R1 mode idle in reset", int'(mode_o), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(vpp_en_o === 1'b0 && mode_o === 2'b00, "R6 idle after reset",
        int'(vpp_en_o), 0);
  endtask

  task automatic test_read();
    int vpp_seen;
    @(negedge clk);
    rd_req = 1'b1;
    @(negedge clk);
    chk(mode_o === 2'b01, "R10 read mode one cycle after request", int'(mode_o), 1);
    vpp_seen = 0;
    repeat (5) begin
      if (vpp_en_o || wr_pulse_o) vpp_seen++;
      @(negedge clk);
    end
    chk(vpp_seen == 0, "R6 supply off during read", vpp_seen, 0);
    chk(mode_o === 2'b01, "R10 read mode held", int'(mode_o), 1);
    rd_req = 1'b0;
    @(negedge clk);
    chk(mode_o === 2'b00, "R10 mode idle after read drops", int'(mode_o), 0);
  endtask

  task automatic test_mid_reset();
    int g;
    @(negedge clk);
    wr_req = 1'b1; wr_sel_reset = 1'b0;
    @(negedge clk);
    wr_req = 1'b0;
    g = 0;
    while (!wr_pulse_o && g < GUARD) begin g++; @(negedge clk); end
    chk(wr_pulse_o === 1'b1, "R1 pulse reached before reset", int'(wr_pulse_o), 1);
    #1 rst_n = 1'b0;
    #0.5;
    chk(vpp_en_o === 1'b0 && wr_pulse_o === 1'b0, "R1 immediate clear on reset",
        int'(vpp_en_o) + int'(wr_pulse_o), 0);
    do_reset();
    chk(vpp_en_o === 1'b0 && mode_o === 2'b00 && done_o === 1'b0,
        "R1 idle after mid-sequence reset", int'(mode_o), 0);
  endtask

  initial begin
    checks = 0; errors = 0; cyc = 0;
    rst_n = 1'b0; wr_req = 1'b0; wr_sel_reset = 1'b0; rd_req = 1'b0;
    test_reset_state();
    run_write(1'b0, 1'b0, 1'b0, "set");
    run_write(1'b1, 1'b0, 1'b0, "reset");
    run_write(1'b0, 1'b1, 1'b0, "R8 write over read");
    run_write(1'b1, 1'b0, 1'b1, "R9 requests during pulse");
    test_read();
    test_mid_reset();
    run_write(1'b1, 1'b1, 1'b0, "R8 after reset");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule